// File: doc/BRIEF.md
# Programmable Two-Dimensional Scan Address Generator

This block walks a rectangular pixel map in an order set by a small program and emits one coordinate per clock. For each point it gives the column, the row and the linear memory address. The program is a table of scan primitives. Each primitive is a unit step vector, a step count and an optional edge condition that ends the primitive early. A run starts at column 1, row 1 and then executes the following parts in order:

- a lead-in primitive;
- a loop body, repeated a programmable number of times;
- a pivot primitive;
- the loop body again, with its entries in reverse order and its edge conditions mirrored;
- the lead-in primitive once more, also mirrored.

With a six-entry program, this schedule produces the 8x8 zigzag scan used by block transform coders.

Software or a controller writes the primitive table while the generator is idle and then pulses `start`. The coordinate stream uses a valid/ready handshake:

- A coordinate is transferred on every rising edge where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the presented coordinate and address stay frozen.
- `out_valid` never depends on `out_ready` in the same cycle.
- When `out_ready` stays high, a new coordinate follows on every clock.

A single-cycle `done` pulse marks the end of a run. Addresses come from counter logic and need no memory access.

Top module: `scan_agen`

## Requirements
- R1: During and straight after reset, `out_valid` and `done` are low.
- R2: In the idle state, a `start` sampled high makes `out_valid` high in the next cycle. The first coordinate is column 1, row 1, and the address equals the base.
- R3: A table entry is 10 bits: step dx in [9:8] and step dy in [7:6], both two's complement in -1..+1, step count in [5:2], and edge code in [1:0]. The edge codes are 0 none, 1 left, 2 top, 3 none. Writes are stored only while the generator is idle. Writes made during a run have no effect on that run or on later runs.
- R4: Each accepted coordinate is followed by one step of the active primitive. A primitive takes as many steps as its count, with a count of 0 treated as 1. After any step that lands on its edge, the primitive ends and the next primitive starts on the next step. Forward runs use left edge = column 1 and top edge = row 1.
- R5: Entry 0 is the lead-in. Entries 1..L form the body, repeated R times; L is clamped to 1..DEPTH-2 and R of 0 counts as 1. Entry L+1 is the pivot. The replay then runs entries L..1, R times, and finishes with entry 0. The replay keeps the same step vectors, but the left edge becomes row HEIGHT and the top edge becomes column WIDTH.
- R6: The six-entry zigzag program produces the 64 coordinates of an 8x8 zigzag, each exactly once. The sequence begins (1,1), (2,1), (1,2), (1,3), (2,2), (3,1), (4,1).
- R7: `out_addr` equals base + (row-1)*WIDTH + (column-1). The base is captured at start.
- R8: While `out_valid` is high and `out_ready` is low, the coordinate and address hold. With `out_ready` held high, one coordinate is transferred per clock with no gaps.
- R9: `done` is high for exactly one cycle: the cycle after the last coordinate is accepted. In that cycle `out_valid` is low.
- R10: A `start` pulse during a run is ignored, and the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a run when idle |
| cfg_body_len | input | IW | Number of loop-body entries, captured at start |
| cfg_reps | input | RW | Loop repeat count, captured at start |
| cfg_base | input | AW | Base address, captured at start |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IW | Table entry index |
| tbl_wdata | input | 10 | Primitive entry, packed as in R3 |
| out_valid | output | 1 | Coordinate is valid |
| out_ready | input | 1 | Consumer accepts the coordinate |
| out_x | output | XW | Column, 1-based |
| out_y | output | YW | Row, 1-based |
| out_addr | output | AW | Linear address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The first coordinate is due one cycle after the edge that samples `start`. Each later coordinate replaces the accepted one at the very next rising edge. `done` rises one edge after the last accept and falls at the following edge. The bench drives inputs and reads outputs only at falling edges, so each sample shows the state left by the preceding rising edge. Each check is made at the exact falling edge where these latencies place the result: the first sample after `start`, every sample where an accept is recorded, and the two samples after the final accept.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Edge condition that can end a primitive early.
  typedef enum logic [1:0] {
    STOP_NONE  = 2'd0,
    STOP_LEFT  = 2'd1,
    STOP_TOP   = 2'd2,
    STOP_SPARE = 2'd3
  } stop_e;

  // One scan primitive: unit step, step count, stop condition.
  typedef struct packed {
    logic signed [1:0] dx;
    logic signed [1:0] dy;
    logic [3:0]        cnt;
    stop_e             stop_sel;
  } prim_t;

  // Program phases of a run.
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_LEAD     = 3'd1,
    PH_BODY_FWD = 3'd2,
    PH_PIVOT    = 3'd3,
    PH_BODY_REV = 3'd4,
    PH_TAIL     = 3'd5
  } phase_e;

endpackage

// File: rtl/scan_prim_table.sv
module scan_prim_table
  import scan_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  prim_t         wr_data,
  input  logic [IW-1:0] rd_addr,
  output prim_t         rd_data
);

  prim_t [DEPTH-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en && !lock && (int'(wr_addr) < DEPTH)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
  end

  // R3: no entry changes while a run is in progress
  a_r3_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem));

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          move,
  input  logic [IW-1:0] cfg_len,
  input  logic [RW-1:0] cfg_reps,
  output logic [IW-1:0] rd_idx,
  output logic          nxt_mirror,
  output logic          busy,
  output logic          at_tail
);

  localparam int MAXLEN = DEPTH - 2;

  phase_e        phase, nxt_phase;
  logic [IW-1:0] idx, nxt_idx;
  logic [RW-1:0] rep, nxt_rep;
  logic [IW-1:0] len_q, len_w;
  logic [RW-1:0] reps_q, reps_w;

  always_comb begin
    if (cfg_len == '0)                   len_w = IW'(1);
    else if (int'(cfg_len) > MAXLEN)     len_w = IW'(MAXLEN);
    else                                 len_w = cfg_len;
    reps_w = (cfg_reps == '0) ? RW'(1) : cfg_reps;
  end

  // Position of the primitive that follows the current one.
  always_comb begin
    nxt_phase = phase;
    nxt_idx   = idx;
    nxt_rep   = rep;
    unique case (phase)
      PH_IDLE: begin
        nxt_phase = PH_LEAD;
        nxt_idx   = '0;
        nxt_rep   = RW'(1);
      end
      PH_LEAD: begin
        nxt_phase = PH_BODY_FWD;
        nxt_idx   = IW'(1);
        nxt_rep   = RW'(1);
      end
      PH_BODY_FWD: begin
        if (idx < len_q) begin
          nxt_idx = idx + IW'(1);
        end else if (rep < reps_q) begin
          nxt_idx = IW'(1);
          nxt_rep = rep + RW'(1);
        end else begin
          nxt_phase = PH_PIVOT;
          nxt_idx   = len_q + IW'(1);
        end
      end
      PH_PIVOT: begin
        nxt_phase = PH_BODY_REV;
        nxt_idx   = len_q;
        nxt_rep   = RW'(1);
      end
      PH_BODY_REV: begin
        if (idx > IW'(1)) begin
          nxt_idx = idx - IW'(1);
        end else if (rep < reps_q) begin
          nxt_idx = len_q;
          nxt_rep = rep + RW'(1);
        end else begin
          nxt_phase = PH_TAIL;
          nxt_idx   = '0;
        end
      end
      PH_TAIL: begin
        nxt_phase = PH_IDLE;
        nxt_idx   = '0;
      end
      default: begin
        nxt_phase = PH_IDLE;
        nxt_idx   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      rep    <= '0;
      len_q  <= IW'(1);
      reps_q <= RW'(1);
    end else if (move) begin
      phase <= nxt_phase;
      idx   <= nxt_idx;
      rep   <= nxt_rep;
      if (phase == PH_IDLE) begin
        len_q  <= len_w;
        reps_q <= reps_w;
      end
    end
  end

  assign rd_idx     = nxt_idx;
  assign nxt_mirror = (nxt_phase == PH_BODY_REV) || (nxt_phase == PH_TAIL);
  assign busy       = (phase != PH_IDLE);
  assign at_tail    = (phase == PH_TAIL);

  // R5: body positions stay inside the captured body length
  a_r5_body_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BODY_FWD || phase == PH_BODY_REV) |-> (idx >= IW'(1) && idx <= len_q));

  // R5: the pivot is entered only from the forward body
  a_r5_pivot_after_body: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_PIVOT) |-> $past(phase) == PH_BODY_FWD);

  // R5: the mirrored tail is entered only from the reversed body
  a_r5_tail_after_rev: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_TAIL) |-> $past(phase) == PH_BODY_REV);

endmodule

// File: rtl/scan_step_engine.sv
module scan_step_engine
  import scan_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 8,
  parameter int XW     = $clog2(WIDTH + 1),
  parameter int YW     = $clog2(HEIGHT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          step_cont,
  input  logic          step_new,
  input  logic          fin,
  input  prim_t         nxt_prim,
  input  logic          nxt_mirror,
  output logic          valid,
  output logic          exhausted,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y
);

  prim_t         act;
  logic          mir;
  logic [3:0]    rem;
  logic          stopped;

  prim_t         p;
  logic          m;
  logic [XW-1:0] sx;
  logic [YW-1:0] sy;
  logic          hit;
  logic [3:0]    nxt_cnt;

  always_comb begin
    p  = step_new ? nxt_prim   : act;
    m  = step_new ? nxt_mirror : mir;
    sx = x + {{(XW-2){p.dx[1]}}, p.dx};
    sy = y + {{(YW-2){p.dy[1]}}, p.dy};
    unique case (p.stop_sel)
      STOP_LEFT: hit = m ? (sy == YW'(HEIGHT)) : (sx == XW'(1));
      STOP_TOP:  hit = m ? (sx == XW'(WIDTH))  : (sy == YW'(1));
      default:   hit = 1'b0;
    endcase
    nxt_cnt = (nxt_prim.cnt == 4'd0) ? 4'd1 : nxt_prim.cnt;
  end

  assign exhausted = (rem == 4'd0) || stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x       <= XW'(1);
      y       <= YW'(1);
      act     <= '0;
      mir     <= 1'b0;
      rem     <= 4'd0;
      stopped <= 1'b0;
      valid   <= 1'b0;
    end else if (go) begin
      x       <= XW'(1);
      y       <= YW'(1);
      act     <= nxt_prim;
      mir     <= nxt_mirror;
      rem     <= nxt_cnt;
      stopped <= 1'b0;
      valid   <= 1'b1;
    end else if (step_cont) begin
      x       <= sx;
      y       <= sy;
      rem     <= rem - 4'd1;
      stopped <= hit;
    end else if (step_new) begin
      x       <= sx;
      y       <= sy;
      act     <= nxt_prim;
      mir     <= nxt_mirror;
      rem     <= nxt_cnt - 4'd1;
      stopped <= hit;
    end else if (fin) begin
      valid   <= 1'b0;
    end
  end

  // R4: every step moves at most one position along each axis
  a_r4_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    (step_cont || step_new) |=>
      (int'(x) <= int'($past(x)) + 1) && (int'($past(x)) <= int'(x) + 1) &&
      (int'(y) <= int'($past(y)) + 1) && (int'($past(y)) <= int'(y) + 1));

  // R4: a primitive that reached its edge is never stepped again
  a_r4_stop_ends_prim: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && stopped) |-> !step_cont);

endmodule

// File: rtl/scan_agen.sv
module scan_agen
  import scan_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int HEIGHT = 8,
  parameter int DEPTH  = 8,
  parameter int RW     = 4,
  parameter int AW     = 16,
  localparam int XW    = $clog2(WIDTH + 1),
  localparam int YW    = $clog2(HEIGHT + 1),
  localparam int IW    = $clog2(DEPTH),
  localparam int PW    = $bits(prim_t)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] cfg_body_len,
  input  logic [RW-1:0] cfg_reps,
  input  logic [AW-1:0] cfg_base,
  input  logic          tbl_we,
  input  logic [IW-1:0] tbl_waddr,
  input  logic [PW-1:0] tbl_wdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic [AW-1:0] out_addr,
  output logic          done
);

  logic          busy, at_tail, nxt_mirror, exhausted;
  logic [IW-1:0] rd_idx;
  prim_t         rd_prim;
  logic          accept, go, adv, fin, step_cont;
  logic [AW-1:0] base_q, row_off, col_off;

  assign accept    = out_valid && out_ready;
  assign go        = start && !busy;
  assign adv       = accept && exhausted && !at_tail;
  assign fin       = accept && exhausted && at_tail;
  assign step_cont = accept && !exhausted;

  scan_prim_table #(.DEPTH(DEPTH), .IW(IW)) tbl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (busy),
    .wr_en   (tbl_we),
    .wr_addr (tbl_waddr),
    .wr_data (prim_t'(tbl_wdata)),
    .rd_addr (rd_idx),
    .rd_data (rd_prim)
  );

  scan_sequencer #(.DEPTH(DEPTH), .IW(IW), .RW(RW)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .move       (go || adv || fin),
    .cfg_len    (cfg_body_len),
    .cfg_reps   (cfg_reps),
    .rd_idx     (rd_idx),
    .nxt_mirror (nxt_mirror),
    .busy       (busy),
    .at_tail    (at_tail)
  );

  scan_step_engine #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .XW(XW), .YW(YW)) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .step_cont  (step_cont),
    .step_new   (adv),
    .fin        (fin),
    .nxt_prim   (rd_prim),
    .nxt_mirror (nxt_mirror),
    .valid      (out_valid),
    .exhausted  (exhausted),
    .x          (out_x),
    .y          (out_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      if (go) base_q <= cfg_base;
      done <= fin;
    end
  end

  always_comb begin
    row_off  = AW'(out_y - YW'(1)) * AW'(WIDTH);
    col_off  = AW'(out_x - XW'(1));
    out_addr = base_q + row_off + col_off;
  end

  // R8: a stalled coordinate is held unchanged
  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      out_valid && $stable(out_x) && $stable(out_y) && $stable(out_addr));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done follows an accepted coordinate and the stream is closed
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && $past(out_valid && out_ready)));

  // R10: a run in progress is not restarted
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !accept) |=> out_valid && $stable(out_x) && $stable(out_y));

endmodule

// File: tb/scan_agen_tb_top.sv
`timescale 1ns/1ps
module scan_agen_tb_top;

  localparam int W = 8;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cfg_body_len = '0;
  logic [3:0]  cfg_reps = '0;
  logic [15:0] cfg_base = '0;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_waddr = '0;
  logic [9:0]  tbl_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_x;
  logic [3:0]  out_y;
  logic [15:0] out_addr;
  logic        done;

  int checks = 0;
  int errors = 0;
  int ref_x [64];
  int ref_y [64];
  int got_x [64];
  int got_y [64];

  always #2 clk = ~clk;

  scan_agen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_body_len(cfg_body_len), .cfg_reps(cfg_reps), .cfg_base(cfg_base),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_addr(out_addr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] enc(input int dx, input int dy, input int cnt, input int st);
    return {2'(dx), 2'(dy), 4'(cnt), 2'(st)};
  endfunction

  task automatic wr_entry(input int idx, input logic [9:0] val);
    tbl_we = 1'b1; tbl_waddr = 3'(idx); tbl_wdata = val;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // R3 encoding: left edge code 1, top edge code 2
  task automatic load_zigzag();
    wr_entry(0, enc( 1,  0, 1, 0));
    wr_entry(1, enc(-1,  1, 8, 1));
    wr_entry(2, enc( 0,  1, 1, 0));
    wr_entry(3, enc( 1, -1, 8, 2));
    wr_entry(4, enc( 1,  0, 1, 0));
    wr_entry(5, enc(-1,  1, 8, 1));
    cfg_body_len = 3'd4; cfg_reps = 4'd3;
  endtask

  task automatic ref_zigzag();
    int k = 0;
    for (int d = 0; d < W + H - 1; d++) begin
      int lo = (d > W - 1) ? d - (W - 1) : 0;
      int hi = (d < W - 1) ? d : W - 1;
      if (d % 2 == 1) begin
        for (int c = hi; c >= lo; c--) begin ref_x[k] = c + 1; ref_y[k] = d - c + 1; k++; end
      end else begin
        for (int c = lo; c <= hi; c++) begin ref_x[k] = c + 1; ref_y[k] = d - c + 1; k++; end
      end
    end
  endtask

  // Program B: lead-in count 0 (acts as 1), body south x2 twice, pivot north-east stop at top
  task automatic load_progb();
    wr_entry(0, enc( 1,  0,  0, 0));
    wr_entry(1, enc( 0,  1,  2, 0));
    wr_entry(2, enc( 1, -1, 15, 2));
    cfg_body_len = 3'd1; cfg_reps = 4'd2;
  endtask

  task automatic ref_progb();
    int bx [15] = '{1,2,2,2,2,2,3,4,5,6,6,6,6,6,7};
    int by [15] = '{1,1,2,3,4,5,4,3,2,1,2,3,4,5,5};
    for (int i = 0; i < 15; i++) begin ref_x[i] = bx[i]; ref_y[i] = by[i]; end
  endtask

  // mode 0: ready high, 1: ready low every third cycle, 2: pseudo-random,
  // 3: ready high plus a table write and a start pulse mid-run
  task automatic run_scan(input int n, input int mode, input int base,
                          input string tag, output int ncyc);
    int acc = 0;
    int cyc = 0;
    bit pv = 1'b0;
    bit injected = 1'b0;
    int px = 0, py = 0, pa = 0;
    logic [7:0] lf = 8'h5A;
    cfg_base = 16'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid === 1'b1, "R2", "valid after start", int'(out_valid), 1);
    chk(out_x == 4'd1 && out_y == 4'd1, "R2", "first coordinate x*16+y", int'(out_x)*16 + int'(out_y), 17);
    chk(out_addr == 16'(base), "R2", "first address", int'(out_addr), base);
    while (acc < n && cyc < 3000) begin
      tbl_we = 1'b0; start = 1'b0;
      case (mode)
        1: out_ready = ((cyc % 3) != 1);
        2: begin lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; out_ready = lf[0]; end
        3: begin
          out_ready = 1'b1;
          if (acc == 5 && !injected) begin
            tbl_we = 1'b1; tbl_waddr = 3'd1; tbl_wdata = enc(1, 1, 3, 0);
            start = 1'b1; injected = 1'b1;
          end
        end
        default: out_ready = 1'b1;
      endcase
      if (pv) begin
        chk(out_valid === 1'b1, "R8", "valid held under stall", int'(out_valid), 1);
        chk(int'(out_x) == px && int'(out_y) == py && int'(out_addr) == pa, "R8",
            "coordinate held under stall (addr)", int'(out_addr), pa);
      end
      if (out_valid && out_ready) begin
        got_x[acc] = int'(out_x); got_y[acc] = int'(out_y);
        chk(int'(out_x) == ref_x[acc], tag, $sformatf("x at %0d", acc), int'(out_x), ref_x[acc]);
        chk(int'(out_y) == ref_y[acc], tag, $sformatf("y at %0d", acc), int'(out_y), ref_y[acc]);
        chk(int'(out_addr) == base + (ref_y[acc] - 1) * W + (ref_x[acc] - 1), "R7",
            $sformatf("address at %0d", acc), int'(out_addr),
            base + (ref_y[acc] - 1) * W + (ref_x[acc] - 1));
        acc++;
      end
      pv = out_valid && !out_ready;
      px = int'(out_x); py = int'(out_y); pa = int'(out_addr);
      cyc++;
      @(negedge clk);
    end
    tbl_we = 1'b0; start = 1'b0; out_ready = 1'b1;
    chk(acc == n, tag, "coordinates accepted", acc, n);
    chk(done === 1'b1, "R9", "done after last accept", int'(done), 1);
    chk(out_valid === 1'b0, "R9", "valid low with done", int'(out_valid), 0);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle only", int'(done), 0);
    ncyc = cyc;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    chk(done === 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && done === 1'b0, "R1", "idle after reset", int'(out_valid), 0);
  endtask

  task automatic t_zigzag_stream();
    int ncyc;
    int seen [64];
    int uniq = 0;
    int fx [7] = '{1,2,1,1,2,3,4};
    int fy [7] = '{1,1,2,3,2,1,1};
    load_zigzag();
    ref_zigzag();
    run_scan(64, 0, 256, "R6", ncyc);
    chk(ncyc == 64, "R8", "cycles for 64 with ready high", ncyc, 64);
    for (int i = 0; i < 7; i++)
      chk(got_x[i] == fx[i] && got_y[i] == fy[i], "R6", $sformatf("leading step %0d x", i), got_x[i], fx[i]);
    for (int i = 0; i < 64; i++) seen[i] = 0;
    for (int i = 0; i < 64; i++)
      if (got_x[i] >= 1 && got_x[i] <= W && got_y[i] >= 1 && got_y[i] <= H)
        seen[(got_y[i] - 1) * W + got_x[i] - 1]++;
    for (int i = 0; i < 64; i++) if (seen[i] == 1) uniq++;
    chk(uniq == 64, "R6", "cells visited exactly once", uniq, 64);
    // mirrored replay: after the anti-diagonal the scan turns east along the last row
    chk(got_x[36] == 2 && got_y[36] == 8, "R5", "first replay coordinate x", got_x[36], 2);
    chk(got_x[63] == 8 && got_y[63] == 8, "R5", "final coordinate x", got_x[63], 8);
  endtask

  task automatic t_zigzag_backpressure();
    int ncyc;
    ref_zigzag();
    run_scan(64, 1, 512, "R5", ncyc);
    chk(ncyc > 64, "R8", "stalls add cycles", ncyc, 65);
    run_scan(64, 2, 0, "R5", ncyc);
  endtask

  task automatic t_progb();
    int ncyc;
    load_progb();
    ref_progb();
    run_scan(15, 0, 64, "R4", ncyc);
    chk(got_x[9] == 6 && got_y[9] == 1, "R4", "pivot stopped at top row (x)", got_x[9], 6);
    chk(got_x[14] == 7, "R3", "table reload used new program (last x)", got_x[14], 7);
  endtask

  task automatic t_busy_ignored();
    int ncyc;
    ref_progb();
    run_scan(15, 3, 1000, "R10", ncyc);
    run_scan(15, 0, 1000, "R3", ncyc);
  endtask

  initial begin
    #600000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zigzag_stream();
    t_zigzag_backpressure();
    t_progb();
    t_busy_ignored();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule